// File: doc/BRIEF.md
# UART with automatic RTS/CTS flow control

This block is a serial transmitter and receiver pair that manages the modem handshake lines by itself. Bytes to send enter a transmit queue through a valid/ready interface. They leave on `txd` as 8N1 frames: a low start bit, eight data bits with the least significant bit first, then a high stop bit. Each bit lasts 16 oversampling ticks. One tick occurs every `baud_div + 1` clock cycles. The receiver decodes frames on `rxd` into a receive queue, and the consumer drains that queue through a second valid/ready interface.

On the receive side, the request line can follow the queue fill level automatically. The request is withdrawn once the number of stored characters reaches a programmable watermark, and it returns as soon as the count falls back below it. On the transmit side, the clear line can gate the start of each character. The clear line is synchronized first. A withdrawal that arrives in the middle of a character never truncates that character: the current frame is finished, and the line then rests at mark until clearance returns. The two automatic behaviours have separate enables. When the request behaviour is off, a software level drives the request pin.

Top module: `uart_fc`

## Requirements
- R1: Each transmitted character is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Every bit is 16 ticks long, and one tick occurs every `baud_div + 1` clocks. The idle level of `txd` is high.
- R2: Valid 8N1 frames on `rxd` are stored, and `rx_data`/`rx_valid` present them in arrival order. A byte leaves the queue on a clock where `rx_valid` and `rx_ready` are both high.
- R3: With `auto_rts_en` = 1, `rts_n` is 1 whenever the receive count is equal to or greater than `rts_watermark`. It is 0 whenever the count is below the watermark, and this is evaluated on every clock.
- R4: With `auto_rts_en` = 0, `rts_n` equals the inverse of `rts_sw_level`.
- R5: With `auto_cts_en` = 1, a character starts only when `cts_n`, after a two-flop synchronizer, reads 0. While `cts_n` is 1, queued characters wait and `txd` stays high.
- R6: If `cts_n` rises while a character is being shifted out, that character is finished in full. `txd` then stays high and no further character starts until `cts_n` is 0 again, after which the remaining queued characters are sent in order.
- R7: With `auto_cts_en` = 0, `cts_n` has no effect, and queued characters are sent as soon as they are available.
- R8: The receive queue holds 16 characters. A character that completes while the queue is full is dropped, the 16 stored characters are kept intact, and `rx_overrun` becomes 1 and stays 1 until reset.
- R9: After reset, `txd` is 1, `tx_ready` is 1, `rx_valid` is 0 and `rx_overrun` is 0. With `auto_rts_en` = 1 and a nonzero watermark, `rts_n` is 0.
- R10: The transmit queue holds 16 characters. `tx_ready` is 0 while it is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clocks per oversampling tick, minus one |
| rts_watermark | input | CW | Receive fill level that withdraws the request |
| auto_rts_en | input | 1 | 1: request follows the receive fill level |
| auto_cts_en | input | 1 | 1: clear line gates the start of each character |
| rts_sw_level | input | 1 | Request level used when automatic request is off (1 = asserted) |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| rx_data | output | 8 | Oldest received byte |
| rx_valid | output | 1 | Receive queue is not empty |
| rx_ready | input | 1 | Consumer takes `rx_data` |
| rx_overrun | output | 1 | Sticky flag: a received byte was dropped |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rts_n | output | 1 | Request to send, active low |
| cts_n | input | 1 | Clear to send, active low |

## Verification
A receive count that drifts from the true number of stored characters appears on `rts_n` in the same clock as the error, because the pin is compared against the watermark on every cycle. Such a drift also appears as a missing or extra byte on `rx_data` once the queue is drained. A transmit state machine that leaves idle at the wrong moment shows a low `txd` while the clear line is withdrawn, within the next clock. A bit counter or shift register that is off by one corrupts the byte seen at mid-bit, within one character time of 160 ticks. A lost overrun flag shows within a cycle of the dropped frame.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_START = 2'd1,
    SER_DATA  = 2'd2,
    SER_STOP  = 2'd3
  } ser_state_e;
endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem_q[rptr_q];
  assign count   = count_q;

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    count_d = count_q;
    if (do_push) wptr_d = (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) count_d = count_q + 1'b1;
    else if (do_pop && !do_push) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      count_q <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= wdata;
  end
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS = 16,
  localparam int TW = $clog2(OVS),
  localparam int BW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cts_ok,
  input  logic              cts_gate_en,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              fifo_pop,
  output logic              txd,
  output logic              busy
);
  localparam logic [TW-1:0] LAST_TICK = TW'(OVS - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

  ser_state_e        state_q, state_d;
  logic [TW-1:0]     tcnt_q, tcnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              may_start;

  assign may_start = !fifo_empty && (!cts_gate_en || cts_ok);

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    fifo_pop = 1'b0;
    case (state_q)
      SER_IDLE: begin
        if (may_start) begin
          fifo_pop = 1'b1;
          sh_d     = fifo_data;
          tcnt_d   = '0;
          state_d  = SER_START;
        end
      end
      SER_START: begin
        if (tick) begin
          if (tcnt_q == LAST_TICK) begin
            tcnt_d  = '0;
            bit_d   = '0;
            state_d = SER_DATA;
          end else tcnt_d = tcnt_q + 1'b1;
        end
      end
      SER_DATA: begin
        if (tick) begin
          if (tcnt_q == LAST_TICK) begin
            tcnt_d = '0;
            sh_d   = sh_q >> 1;
            if (bit_q == LAST_BIT) state_d = SER_STOP;
            else bit_d = bit_q + 1'b1;
          end else tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: begin
        if (tick) begin
          if (tcnt_q == LAST_TICK) state_d = SER_IDLE;
          else tcnt_d = tcnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      tcnt_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign txd  = (state_q == SER_START) ? 1'b0 :
                (state_q == SER_DATA)  ? sh_q[0] : 1'b1;
  assign busy = (state_q != SER_IDLE);
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
  import uart_fc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS = 16,
  localparam int TW = $clog2(OVS),
  localparam int BW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  output logic              push,
  output logic [DATA_W-1:0] data
);
  localparam logic [TW-1:0] LAST_TICK = TW'(OVS - 1);
  localparam logic [TW-1:0] MID_TICK  = TW'(OVS / 2 - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(DATA_W - 1);

  ser_state_e        state_q, state_d;
  logic [TW-1:0]     tcnt_q, tcnt_d;
  logic [BW-1:0]     bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              rxd_m, rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd;
      rxd_s <= rxd_m;
    end
  end

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    push    = 1'b0;
    case (state_q)
      SER_IDLE: begin
        if (tick && !rxd_s) begin
          tcnt_d  = '0;
          state_d = SER_START;
        end
      end
      SER_START: begin
        if (tick) begin
          if (tcnt_q == MID_TICK) begin
            tcnt_d  = '0;
            bit_d   = '0;
            state_d = rxd_s ? SER_IDLE : SER_DATA;
          end else tcnt_d = tcnt_q + 1'b1;
        end
      end
      SER_DATA: begin
        if (tick) begin
          if (tcnt_q == LAST_TICK) begin
            tcnt_d = '0;
            sh_d   = {rxd_s, sh_q[DATA_W-1:1]};
            if (bit_q == LAST_BIT) state_d = SER_STOP;
            else bit_d = bit_q + 1'b1;
          end else tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: begin
        if (tick) begin
          if (tcnt_q == LAST_TICK) begin
            push    = rxd_s;
            state_d = SER_IDLE;
          end else tcnt_d = tcnt_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      tcnt_q  <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
    end
  end

  assign data = sh_q;
endmodule

// File: rtl/uart_fc.sv
module uart_fc #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  parameter int OVS = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [CW-1:0]    rts_watermark,
  input  logic             auto_rts_en,
  input  logic             auto_cts_en,
  input  logic             rts_sw_level,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_overrun,
  input  logic             rxd,
  output logic             txd,
  output logic             rts_n,
  input  logic             cts_n
);
  logic             rst_m, rst_s;
  logic [DIV_W-1:0] div_q, div_d;
  logic             tick;
  logic             cts_m, cts_s, cts_ok;
  logic             ovr_q, ovr_d;
  logic             tx_full, tx_empty, tx_pop, tx_busy;
  logic [7:0]       tx_head;
  logic [CW-1:0]    tx_count, rx_count;
  logic             rx_full, rx_empty, rx_push;
  logic [7:0]       rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  assign tick  = (div_q == baud_div);
  assign div_d = tick ? '0 : div_q + 1'b1;
  assign ovr_d = ovr_q | (rx_push & rx_full);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      div_q <= '0;
      cts_m <= 1'b1;
      cts_s <= 1'b1;
      ovr_q <= 1'b0;
    end else begin
      div_q <= div_d;
      cts_m <= cts_n;
      cts_s <= cts_m;
      ovr_q <= ovr_d;
    end
  end

  assign cts_ok = !cts_s;

  uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_s), .push(tx_valid), .wdata(tx_data), .pop(tx_pop),
    .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_fc_tx #(.DATA_W(8), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_s), .tick(tick), .cts_ok(cts_ok),
    .cts_gate_en(auto_cts_en), .fifo_empty(tx_empty), .fifo_data(tx_head),
    .fifo_pop(tx_pop), .txd(txd), .busy(tx_busy)
  );

  uart_fc_rx #(.DATA_W(8), .OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_s), .tick(tick), .rxd(rxd),
    .push(rx_push), .data(rx_byte)
  );

  uart_fc_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_s), .push(rx_push), .wdata(rx_byte),
    .pop(rx_ready), .rdata(rx_data), .count(rx_count), .full(rx_full),
    .empty(rx_empty)
  );

  assign tx_ready   = !tx_full;
  assign rx_valid   = !rx_empty;
  assign rx_overrun = ovr_q;
  assign rts_n      = auto_rts_en ? (rx_count >= rts_watermark) : !rts_sw_level;
endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          auto_rts_en,
  input logic          auto_cts_en,
  input logic          rts_sw_level,
  input logic [CW-1:0] rts_watermark,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rts_n,
  input logic          txd,
  input logic          tx_busy,
  input logic          tx_empty,
  input logic          cts_ok,
  input logic          tx_ready,
  input logic          rx_overrun
);
  assert_rts_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    auto_rts_en |-> (rts_n == (rx_count >= rts_watermark)));

  assert_rts_sw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_rts_en |-> (rts_n != rts_sw_level));

  assert_cts_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> (!$past(auto_cts_en) || $past(cts_ok)));

  assert_start_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(!tx_empty));

  assert_idle_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);

  assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  assert_tx_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> (tx_count == CW'(DEPTH)));
endmodule

bind uart_fc uart_fc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
  .rts_sw_level(rts_sw_level), .rts_watermark(rts_watermark),
  .rx_count(rx_count), .tx_count(tx_count), .rts_n(rts_n), .txd(txd),
  .tx_busy(tx_busy), .tx_empty(tx_empty), .cts_ok(cts_ok),
  .tx_ready(tx_ready), .rx_overrun(rx_overrun)
);

// File: tb/uart_fc_tb.sv
module uart_fc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int DIV_W = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [DIV_W-1:0] baud_div;
  logic [CW-1:0] rts_watermark;
  logic auto_rts_en, auto_cts_en, rts_sw_level;
  logic [7:0] tx_data;
  logic tx_valid, tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_ready, rx_overrun;
  logic rxd, txd, rts_n, cts_n;

  assign rxd = txd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_fc #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rts_watermark(rts_watermark),
    .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .rts_sw_level(rts_sw_level),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_overrun(rx_overrun), .rxd(rxd), .txd(txd), .rts_n(rts_n), .cts_n(cts_n)
  );

  logic [7:0] exp_q[$];
  logic [7:0] exp_b;
  int checks = 0;
  int errors = 0;
  int rx_got = 0;
  int txd_low = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (!txd) txd_low++;
      if (rx_valid && rx_ready) begin
        rx_got++;
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected byte", rx_data, 0);
        else begin
          exp_b = exp_q.pop_front();
          check(rx_data == exp_b, "R2 byte order", rx_data, exp_b);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b, input bit expect_rx);
    while (!tx_ready) cyc(1);
    tx_data = b;
    tx_valid = 1'b1;
    cyc(1);
    tx_valid = 1'b0;
    if (expect_rx) exp_q.push_back(b);
  endtask

  task automatic wait_drain(input int max, input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < max) begin
      @(posedge clk);
      n++;
    end
    #1;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    finish_run();
  end

  initial begin
    int g0, low0;
    logic [7:0] pat;
    rst_n = 1'b0;
    baud_div = '0;
    rts_watermark = CW'(8);
    auto_rts_en = 1'b1;
    auto_cts_en = 1'b0;
    rts_sw_level = 1'b0;
    tx_data = '0;
    tx_valid = 1'b0;
    rx_ready = 1'b1;
    cts_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(5);

    // R9 reset state
    @(negedge clk);
    check(txd == 1'b1, "R9 txd", txd, 1);
    check(tx_ready == 1'b1, "R9 tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    check(rx_overrun == 1'b0, "R9 rx_overrun", rx_overrun, 0);
    check(rts_n == 1'b0, "R9 rts_n", rts_n, 0);
    cyc(1);

    // R1 frame shape on txd
    pat = 8'hA5;
    send(pat, 1);
    begin
      int lim = 0;
      @(negedge clk);
      while (txd && lim < 50) begin
        @(negedge clk);
        lim++;
      end
    end
    repeat (8) @(negedge clk);
    check(txd == 1'b0, "R1 start bit", txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (16) @(negedge clk);
      check(txd == pat[i], "R1 data bit", txd, pat[i]);
    end
    repeat (16) @(negedge clk);
    check(txd == 1'b1, "R1 stop bit", txd, 1);
    wait_drain(400, "R2 first byte");

    // R2 several patterns through loopback
    send(8'h00, 1);
    send(8'hFF, 1);
    send(8'h3C, 1);
    send(8'h81, 1);
    wait_drain(1000, "R2 patterns");

    // R3 watermark
    rts_watermark = CW'(4);
    rx_ready = 1'b0;
    send(8'h11, 1);
    send(8'h22, 1);
    send(8'h33, 1);
    cyc(600);
    @(negedge clk);
    check(rts_n == 1'b0, "R3 below watermark", rts_n, 0);
    cyc(1);
    send(8'h44, 1);
    cyc(220);
    @(negedge clk);
    check(rts_n == 1'b1, "R3 at watermark", rts_n, 1);
    cyc(1);
    rx_ready = 1'b1;
    cyc(1);
    rx_ready = 1'b0;
    @(negedge clk);
    check(rts_n == 1'b0, "R3 drop below", rts_n, 0);
    cyc(1);
    rx_ready = 1'b1;
    wait_drain(50, "R3 drain");
    rts_watermark = CW'(8);

    // R4 software level
    auto_rts_en = 1'b0;
    rts_sw_level = 1'b0;
    @(negedge clk);
    check(rts_n == 1'b1, "R4 sw low", rts_n, 1);
    cyc(1);
    rts_sw_level = 1'b1;
    @(negedge clk);
    check(rts_n == 1'b0, "R4 sw high", rts_n, 0);
    cyc(1);
    auto_rts_en = 1'b1;

    // R5 withheld clearance blocks the start
    auto_cts_en = 1'b1;
    cts_n = 1'b1;
    cyc(5);
    low0 = txd_low;
    g0 = rx_got;
    send(8'h5A, 1);
    cyc(250);
    check(txd_low == low0, "R5 txd held high", txd_low - low0, 0);
    check(rx_got == g0, "R5 nothing sent", rx_got - g0, 0);
    cts_n = 1'b0;
    wait_drain(400, "R5 resumes");

    // R6 withdrawal in mid character
    g0 = rx_got;
    send(8'hC3, 1);
    send(8'h96, 1);
    send(8'h0F, 1);
    cyc(40);
    cts_n = 1'b1;
    cyc(220);
    check(rx_got == g0 + 1, "R6 current char completes", rx_got - g0, 1);
    low0 = txd_low;
    cyc(300);
    check(txd_low == low0, "R6 mark while paused", txd_low - low0, 0);
    check(rx_got == g0 + 1, "R6 no new start", rx_got - g0, 1);
    cts_n = 1'b0;
    wait_drain(800, "R6 remaining");
    check(rx_got == g0 + 3, "R6 count", rx_got - g0, 3);

    // R7 clear line ignored when disabled
    auto_cts_en = 1'b0;
    cts_n = 1'b1;
    g0 = rx_got;
    send(8'h77, 1);
    send(8'hE1, 1);
    wait_drain(600, "R7 sent without clearance");
    check(rx_got == g0 + 2, "R7 count", rx_got - g0, 2);

    // R10 transmit queue full
    auto_cts_en = 1'b1;
    cts_n = 1'b1;
    cyc(5);
    for (int i = 0; i < 16; i++) send(8'(i * 13 + 1), 1);
    @(negedge clk);
    check(tx_ready == 1'b0, "R10 full", tx_ready, 0);
    cyc(1);
    cts_n = 1'b0;
    wait_drain(16 * 170 + 200, "R10 drain");

    // R8 receive overrun
    auto_cts_en = 1'b0;
    rx_ready = 1'b0;
    g0 = rx_got;
    for (int i = 0; i < 17; i++) send(8'(i * 7 + 3), i < 16);
    cyc(17 * 170 + 100);
    @(negedge clk);
    check(rx_overrun == 1'b1, "R8 overrun set", rx_overrun, 1);
    check(rx_valid == 1'b1, "R8 data kept", rx_valid, 1);
    cyc(1);
    rx_ready = 1'b1;
    wait_drain(100, "R8 drain");
    cyc(5);
    @(negedge clk);
    check(rx_got == g0 + 16, "R8 sixteen kept", rx_got - g0, 16);
    check(rx_valid == 1'b0, "R8 extra dropped", rx_valid, 0);
    check(rx_overrun == 1'b1, "R8 sticky", rx_overrun, 1);

    finish_run();
  end
endmodule